// File: doc/BRIEF.md
# Serial/Parallel FIFO Entry Register

This block is the entry stage of a 4-bit-wide FIFO slice. It collects one word from a producer, either as a 4-bit parallel word or as a bit-serial stream, and holds it until the downstream fall-through stack has room. A single marker bit is planted at the top of the register at initialization. Each serial shift moves it one place toward a completion flop, so the register knows it is full after exactly as many serial bits as it has data bits. The active-low full flag is the inverse of that completion flop.

When the stack requests a transfer and reports that its top slot is free, the block raises a one-cycle push strobe with the word on its output. It then records that the word has been handed over, so the same word is never pushed twice. Re-initialization of the register is interlocked in two ways. It waits while parallel load is still high. In a slave slice, chosen by the serial enable level seen during reset, it also waits until the serial enable input goes low. Chained slices therefore re-arm in order. All inputs are sampled on one system clock. The serial clock, serial data and parallel load pass through a synchronizer, and falling edges of the serial clock are detected internally.

Top module: `fsi_entry_reg`

## Requirements
- R1: While rst_n is low at a clock edge, the register initializes: full_n reads 1 and word_out reads 4'b1000 (bit 3 set, bits 2..0 clear).
- R2: While ser_en_n is low and the register is not full, each falling edge of ser_clk shifts ser_din into bit 3 and moves bit 3→2→1→0→completion. The first serial bit ends in bit 0, and after three bits of b0,b1,b2 the word reads {b2,b1,b0,1} with full_n still 1.
- R3: After the fourth serial edge, full_n goes to 0 and the word is {b3,b2,b1,b0}. Further serial edges leave the word unchanged, and the register stays full until it has pushed its word.
- R4: Serial clock edges while ser_en_n is high have no effect on word_out or full_n.
- R5: A high on pload loads par_din into word_out and drives full_n to 0.
- R6: push pulses for one cycle only after a cycle in which the register was full, xfer_req_n was low and stack_top_empty was high. While push is high, word_out carries the word being handed over.
- R7: A word is pushed at most once, even while full_n and xfer_req_n stay low or pload stays high.
- R8: After a push, re-initialization (full_n back to 1) is deferred for as long as pload is high.
- R9: A slice that saw ser_en_n low during reset is a master and re-initializes right after a push. A slice that saw ser_en_n high during reset is a slave and keeps full_n low after a push until ser_en_n goes low.
- R10: If a parallel load and a serial clock falling edge reach the register in the same cycle, the parallel load wins and the serial edge is dropped.
- R11: While stack_top_empty is low, a full register does not push. It pushes once stack_top_empty rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| ser_clk | input | 1 | Serial input clock, falling edge shifts |
| ser_din | input | 1 | Serial data bit |
| ser_en_n | input | 1 | Active-low serial enable; during reset it selects master (low) or slave (high) |
| pload | input | 1 | Parallel load, active high |
| par_din | input | WIDTH | Parallel data word |
| xfer_req_n | input | 1 | Active-low transfer-to-stack request |
| stack_top_empty | input | 1 | Top stack slot can accept a word |
| full_n | output | 1 | Active-low register-full flag |
| word_out | output | WIDTH | Register contents toward the stack |
| push | output | 1 | One-cycle strobe writing word_out into the stack |

## Verification
The bench targets the marker's arrival. A chain that counted wrong would raise full after three or five bits, or leave the first bit in the wrong position. It also targets the double-push hazard under a held transfer request and a held parallel load: a missing handover flag shows up as extra push strobes. The master and slave re-arm rules are checked separately, since a slave that ignored its enable would drop full straight after the push. Finally, a one-cycle parallel load coincides with a serial edge. If the priority were reversed, the shifted value would be seen in place of the loaded word.

// File: rtl/fsi_pkg.sv
package fsi_pkg;

    // Operation applied to the data/marker chain in one cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2,
        OP_INIT  = 2'd3
    } fsi_op_e;

endpackage

// File: rtl/fsi_sync.sv
module fsi_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/fsi_fall_det.sv
module fsi_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    // sampled 1 followed by sampled 0
    assign fall_o = prev_q & ~level_i;

endmodule

// File: rtl/fsi_entry_reg.sv
module fsi_entry_reg #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_din,
    input  logic             ser_en_n,
    input  logic             pload,
    input  logic [WIDTH-1:0] par_din,
    input  logic             xfer_req_n,
    input  logic             stack_top_empty,
    output logic             full_n,
    output logic [WIDTH-1:0] word_out,
    output logic             push
);

    import fsi_pkg::*;

    localparam int                BUS_W     = 3;
    localparam logic [WIDTH-1:0]  INIT_WORD = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] data;    // data bits, marker starts in the top bit
        logic             done;    // completion flop at the end of the chain
        logic             handed;  // word already given to the stack
        logic             master;  // interlock role latched during reset
        logic             push;    // registered write strobe
    } state_t;

    state_t           st_d, st_q;
    fsi_op_e          op;
    logic [BUS_W-1:0] sync_bus;
    logic             sclk_s, sdin_s, pload_s;
    logic             sclk_fall;
    logic             rearm_ok;

    fsi_sync #(
        .WIDTH  (BUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_clk, ser_din, pload}),
        .sync_o  (sync_bus)
    );

    assign {sclk_s, sdin_s, pload_s} = sync_bus;

    fsi_fall_det u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sclk_s),
        .fall_o  (sclk_fall)
    );

    // a master re-arms at once, a slave waits for its enable
    assign rearm_ok = st_q.handed && !pload_s && (st_q.master || !ser_en_n);

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;

        if (rearm_ok)
            op = OP_INIT;
        else if (pload_s)
            op = OP_LOAD;          // parallel load beats a same-cycle serial edge
        else if (sclk_fall && !ser_en_n && !st_q.done)
            op = OP_SHIFT;
        else
            op = OP_HOLD;

        unique case (op)
            OP_LOAD: begin
                st_d.data = par_din;
                st_d.done = 1'b1;
            end
            OP_SHIFT: begin
                st_d.data = {sdin_s, st_q.data[WIDTH-1:1]};
                st_d.done = st_q.data[0];
            end
            OP_INIT: begin
                st_d.data   = INIT_WORD;
                st_d.done   = 1'b0;
                st_d.handed = 1'b0;
            end
            default: ;
        endcase

        if (st_q.done && !st_q.handed && !xfer_req_n && stack_top_empty) begin
            st_d.push   = 1'b1;
            st_d.handed = 1'b1;
        end

        if (!rst_n) begin
            st_d.data   = INIT_WORD;
            st_d.done   = 1'b0;
            st_d.handed = 1'b0;
            st_d.push   = 1'b0;
            st_d.master = ~ser_en_n;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign full_n   = ~st_q.done;
    assign word_out = st_q.data;
    assign push     = st_q.push;

endmodule

// File: rtl/fsi_entry_chk.sv
module fsi_entry_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_req_n,
    input logic stack_top_empty,
    input logic full_n,
    input logic push
);

    logic pushed_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      pushed_q <= 1'b0;
        else if (push)   pushed_q <= 1'b1;
        else if (full_n) pushed_q <= 1'b0;
    end

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> full_n);

    assert_push_conditions_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full_n && $past(!xfer_req_n && stack_top_empty)));

    assert_single_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !pushed_q);

    assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !pushed_q && !push) |=> !full_n);

endmodule

bind fsi_entry_reg fsi_entry_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .xfer_req_n      (xfer_req_n),
    .stack_top_empty (stack_top_empty),
    .full_n          (full_n),
    .push            (push)
);

// File: tb/fsi_entry_reg_test.sv
module fsi_entry_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_en_n = 1'b0;
    logic       pload = 1'b0;
    logic [3:0] par_din = 4'h0;
    logic       xfer_req_n = 1'b1;
    logic       stack_top_empty = 1'b1;
    logic       full_n;
    logic [3:0] word_out;
    logic       push;

    int         n_chk = 0;
    int         n_fail = 0;
    int         push_cnt = 0;
    logic [3:0] last_word = 4'h0;
    bit         finished = 1'b0;

    fsi_entry_reg uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ser_clk         (ser_clk),
        .ser_din         (ser_din),
        .ser_en_n        (ser_en_n),
        .pload           (pload),
        .par_din         (par_din),
        .xfer_req_n      (xfer_req_n),
        .stack_top_empty (stack_top_empty),
        .full_n          (full_n),
        .word_out        (word_out),
        .push            (push)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (push) begin
            push_cnt  <= push_cnt + 1;
            last_word <= word_out;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(bit slave);
        pload = 1'b0; ser_clk = 1'b0; ser_din = 1'b0; par_din = 4'h0;
        xfer_req_n = 1'b1; stack_top_empty = 1'b1; ser_en_n = slave;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic ser_bit(logic b);
        ser_din = b; ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
        tick(4);
    endtask

    task automatic pload_pulse(logic [3:0] w);
        par_din = w; pload = 1'b1;
        tick(1);
        pload = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk("R1 full_n", full_n, 1);
        chk("R1 word", word_out, 4'b1000);
        chk("R1 push", push, 0);
    endtask

    task automatic t_serial;
        do_reset(1'b0);
        ser_bit(1); ser_bit(0); ser_bit(1);
        chk("R2 full_n after 3", full_n, 1);
        chk("R2 word after 3", word_out, 4'b1011);
        ser_bit(1);
        chk("R3 full_n after 4", full_n, 0);
        chk("R3 word after 4", word_out, 4'b1101);
        ser_bit(0); ser_bit(0);
        chk("R3 word after extra edges", word_out, 4'b1101);
        chk("R3 still full", full_n, 0);
    endtask

    task automatic t_ser_disabled;
        do_reset(1'b0);
        ser_en_n = 1'b1;
        ser_bit(1); ser_bit(1); ser_bit(0); ser_bit(1);
        chk("R4 word", word_out, 4'b1000);
        chk("R4 full_n", full_n, 1);
        ser_en_n = 1'b0;
    endtask

    task automatic t_parallel_push;
        int c0;
        do_reset(1'b0);
        c0 = push_cnt;
        pload_pulse(4'b0110);
        tick(6);
        chk("R5 word", word_out, 4'b0110);
        chk("R5 full_n", full_n, 0);
        chk("R6 no push without request", push_cnt - c0, 0);
        xfer_req_n = 1'b0;
        tick(6);
        chk("R6 one push", push_cnt - c0, 1);
        chk("R6 pushed word", last_word, 4'b0110);
        chk("R9 master re-arms", full_n, 1);
        chk("R9 master word re-init", word_out, 4'b1000);
        tick(10);
        chk("R7 no repeat push", push_cnt - c0, 1);
    endtask

    task automatic t_top_busy;
        int c0;
        do_reset(1'b0);
        c0 = push_cnt;
        stack_top_empty = 1'b0; xfer_req_n = 1'b0;
        pload_pulse(4'b1010);
        tick(10);
        chk("R11 no push while top busy", push_cnt - c0, 0);
        chk("R11 still full", full_n, 0);
        stack_top_empty = 1'b1;
        tick(4);
        chk("R11 push once top free", push_cnt - c0, 1);
        chk("R11 pushed word", last_word, 4'b1010);
    endtask

    task automatic t_pload_hold;
        int c0;
        do_reset(1'b0);
        c0 = push_cnt;
        xfer_req_n = 1'b0;
        par_din = 4'b0011; pload = 1'b1;
        tick(12);
        chk("R8 one push with pload high", push_cnt - c0, 1);
        chk("R7 no second push with pload held", push_cnt - c0, 1);
        chk("R8 re-init deferred", full_n, 0);
        pload = 1'b0;
        tick(6);
        chk("R8 re-init after pload low", full_n, 1);
        chk("R8 pushed word", last_word, 4'b0011);
    endtask

    task automatic t_slave;
        int c0;
        do_reset(1'b1);
        c0 = push_cnt;
        xfer_req_n = 1'b0;
        pload_pulse(4'b0101);
        tick(10);
        chk("R9 slave push", push_cnt - c0, 1);
        chk("R9 slave holds full", full_n, 0);
        ser_en_n = 1'b0;
        tick(3);
        chk("R9 slave re-arms on enable", full_n, 1);
        chk("R7 slave single push", push_cnt - c0, 1);
    endtask

    task automatic t_priority;
        do_reset(1'b0);
        ser_din = 1'b0; ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
        par_din = 4'b1001; pload = 1'b1;
        tick(1);
        pload = 1'b0;
        tick(6);
        chk("R10 load wins", word_out, 4'b1001);
        chk("R10 full", full_n, 0);
    endtask

    initial begin
        t_reset();
        t_serial();
        t_ser_disabled();
        t_parallel_push();
        t_top_busy();
        t_pload_hold();
        t_slave();
        t_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule